// File: doc/BRIEF.md
# Counter Overflow Interrupt Enable Mask

This block keeps the per-counter overflow interrupt enables of a performance monitor as one 32-bit mask. Bit 31 belongs to the cycle counter, and bit n (n from 0 to 30) belongs to event counter n. The mask can only be cleared through this block. A system-register port clears bits by writing ones. A companion enable-set path sets bits through a plain pulse vector. An external debug bus port also reaches the mask. That port grades every access as read-write, read-only or error, using the power and lock status inputs.

The block ANDs the mask with the counters' overflow flags and ORs the result into a single registered interrupt request. The parameter `NUM_EVT` sets how many event counters exist. Bits 30 down to `NUM_EVT` are tied to zero. A second parameter chooses whether reset forces the mask to zero or leaves it untouched.

Top module: `ovf_irq_mask`

## Requirements
- R1: With `RST_ZERO_EN=1`, a synchronous low `rst_n` clears the mask and the interrupt output. The first read after reset returns zero.
- R2: A system write with `sys_wr_en` high clears, at the next clock edge, every mask bit whose `sys_wr_data` bit is 1. Bits written 0 keep their value.
- R3: `sys_rd_data` always shows the current mask. Bit 31 is the cycle counter enable and bit n is the enable of event counter n.
- R4: Bits 30 down to `NUM_EVT` always read zero, whatever is set or written.
- R5: A 1 on `en_set[i]` sets implemented bit i at the next edge. When set and clear hit the same bit in the same cycle, the clear wins.
- R6: An external access at the register offset gets an error response if any one of these holds: `core_pwr` is low, `dbl_lock` is high, `os_lock` is high, or `ext_pmu_ok` is low. An errored access changes nothing and returns zero data.
- R7: When every condition of R6 passes and `sw_lock` is high, external access is read-only. An external write is then dropped, leaves the mask unchanged and gets no error.
- R8: When every condition of R6 passes and `sw_lock` is low, an external read returns the mask and an external write clears bits exactly as R2 does.
- R9: `dbg_rdata` is zero for any write, any errored access, and any cycle where `dbg_sel` is low.
- R10: The register answers only at byte offset 0xC60 of `dbg_addr`. An access to any other offset gives no error, returns zero data and does not change the mask.
- R11: `irq` is registered. After each edge it equals the OR over all bits of (`ovf_flags` sampled at that edge AND the mask value taken at that same edge). A clear written in a cycle therefore drops `irq` at the very edge that updates the mask.
- R12: When a system write and an external read-write write occur in the same cycle, every bit set in either data word is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_wr_en | input | 1 | System-register clear write strobe |
| sys_wr_data | input | 32 | Ones select the bits to clear |
| sys_rd_data | output | 32 | Current mask |
| en_set | input | 32 | Set pulses from the companion enable-set path |
| ovf_flags | input | 32 | Per-counter overflow status flags |
| dbg_sel | input | 1 | External bus access strobe |
| dbg_wr | input | 1 | External access is a write |
| dbg_addr | input | 12 | External byte offset |
| dbg_wdata | input | 32 | External write data, ones clear |
| dbg_rdata | output | 32 | External read data |
| dbg_err | output | 1 | External error response |
| core_pwr | input | 1 | Core is powered |
| dbl_lock | input | 1 | Double lock is set |
| os_lock | input | 1 | OS lock is set |
| ext_pmu_ok | input | 1 | External monitor access is allowed |
| sw_lock | input | 1 | Software lock is set |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The external port is driven from a table that takes each status input in turn into its failing value. The table separates the error case from the read-only drop and from the read-write clear. It also includes a wrong offset, which tells address decoding apart from grading. Clear words of 0, of single bits and of all ones, including the unimplemented bits, show whether writes clear only the bits selected and whether the tied-zero bits stay zero. Directed cases set and clear a bit in the same cycle and send system and external clears together. They also clear an enable while its overflow flag stays high, which pins down the cycle in which `irq` falls.

// File: rtl/ovf_irq_pkg.sv
// Shared types and helpers for the overflow interrupt enable mask.
// Assumes a fixed 32-bit register with the cycle counter at bit 31.
package ovf_irq_pkg;
    localparam int REG_W   = 32;
    localparam int CYC_BIT = 31;

    typedef enum logic [1:0] {
        ACC_ERR = 2'd0,
        ACC_RO  = 2'd1,
        ACC_RW  = 2'd2
    } acc_grade_e;

    // Bits that exist: the cycle counter plus event counters 0..n-1.
    function automatic logic [REG_W-1:0] impl_mask(input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < CYC_BIT; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/ovf_acc_grade.sv
// Grades an external access as error, read-only or read-write from the
// power and lock status inputs. Purely combinational; the inputs are
// assumed to be stable, already synchronised levels.
module ovf_acc_grade
    import ovf_irq_pkg::*;
(
    input  logic       core_pwr,
    input  logic       dbl_lock,
    input  logic       os_lock,
    input  logic       ext_pmu_ok,
    input  logic       sw_lock,
    output acc_grade_e grade
);
    logic reach_ok;

    // Purpose: all four access preconditions must hold, else error.
    always_comb begin
        reach_ok = core_pwr && !dbl_lock && !os_lock && ext_pmu_ok;
        if (!reach_ok)    grade = ACC_ERR;
        else if (sw_lock) grade = ACC_RO;
        else              grade = ACC_RW;
    end
endmodule

// File: rtl/ovf_en_store.sv
// Enable mask storage. The next value is (mask | set) & ~clr, restricted
// to implemented bits, so a clear beats a set on the same bit.
// RST_ZERO_EN selects a reset to zero or a reset-free register.
module ovf_en_store #(
    parameter int               W           = 32,
    parameter logic [W-1:0]     IMPL        = '1,
    parameter bit               RST_ZERO_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] mask_d
);
    // Purpose: next mask value with clear priority and tied-off bits.
    always_comb begin
        mask_d = (mask_q | set_vec) & ~clr_vec & IMPL;
    end

    generate
        if (RST_ZERO_EN) begin : g_rst
            // Purpose: mask register with deterministic zero reset.
            always_ff @(posedge clk) begin
                if (!rst_n) mask_q <= '0;
                else        mask_q <= mask_d;
            end
        end else begin : g_norst
            // Purpose: mask register left untouched by reset.
            always_ff @(posedge clk) begin
                mask_q <= mask_d;
            end
        end
    endgenerate
endmodule

// File: rtl/ovf_irq_reduce.sv
// Registered interrupt request: OR over (overflow flag AND next mask).
// Using the next mask makes the request follow a clear at the same edge.
module ovf_irq_reduce #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ovf_flags,
    input  logic [W-1:0] mask_d,
    output logic         irq_q
);
    // Purpose: sample the masked overflow reduction once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(ovf_flags & mask_d);
    end
endmodule

// File: rtl/ovf_irq_mask.sv
// Top of the overflow interrupt enable mask. Merges the clears from the
// system port and the graded external port, holds the mask and drives
// the interrupt. Assumes NUM_EVT in 0..31 and one access per cycle per port.
module ovf_irq_mask
    import ovf_irq_pkg::*;
#(
    parameter int          NUM_EVT     = 6,
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] REG_OFFSET  = 12'hC60,
    parameter bit          RST_ZERO_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_wr_en,
    input  logic [REG_W-1:0]  sys_wr_data,
    output logic [REG_W-1:0]  sys_rd_data,
    input  logic [REG_W-1:0]  en_set,
    input  logic [REG_W-1:0]  ovf_flags,
    input  logic              dbg_sel,
    input  logic              dbg_wr,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [REG_W-1:0]  dbg_wdata,
    output logic [REG_W-1:0]  dbg_rdata,
    output logic              dbg_err,
    input  logic              core_pwr,
    input  logic              dbl_lock,
    input  logic              os_lock,
    input  logic              ext_pmu_ok,
    input  logic              sw_lock,
    output logic              irq
);
    localparam logic [REG_W-1:0]  IMPL     = impl_mask(NUM_EVT);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

    acc_grade_e       grade;
    logic             hit;
    logic [REG_W-1:0] sys_clr;
    logic [REG_W-1:0] ext_clr;
    logic [REG_W-1:0] clr_all;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] mask_d;

    ovf_acc_grade u_grade (
        .core_pwr   (core_pwr),
        .dbl_lock   (dbl_lock),
        .os_lock    (os_lock),
        .ext_pmu_ok (ext_pmu_ok),
        .sw_lock    (sw_lock),
        .grade      (grade)
    );

    // Purpose: decode the external access and build both clear vectors.
    always_comb begin
        hit     = dbg_sel && (dbg_addr == HIT_ADDR);
        sys_clr = sys_wr_en ? sys_wr_data : '0;
        ext_clr = (hit && dbg_wr && grade == ACC_RW) ? dbg_wdata : '0;
        clr_all = sys_clr | ext_clr;
    end

    // Purpose: external response; data only on a granted read.
    always_comb begin
        dbg_err   = hit && (grade == ACC_ERR);
        dbg_rdata = (hit && !dbg_wr && grade != ACC_ERR) ? mask_q : '0;
    end

    ovf_en_store #(
        .W           (REG_W),
        .IMPL        (IMPL),
        .RST_ZERO_EN (RST_ZERO_EN)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (en_set),
        .clr_vec (clr_all),
        .mask_q  (mask_q),
        .mask_d  (mask_d)
    );

    ovf_irq_reduce #(.W(REG_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_flags (ovf_flags),
        .mask_d    (mask_d),
        .irq_q     (irq)
    );

    assign sys_rd_data = mask_q;
endmodule

// File: rtl/ovf_irq_mask_chk.sv
// Property checker for ovf_irq_mask, attached by bind. Observes ports only.
module ovf_irq_mask_chk
    import ovf_irq_pkg::*;
#(
    parameter int          NUM_EVT    = 6,
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] REG_OFFSET = 12'hC60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sys_wr_en,
    input logic [REG_W-1:0]  sys_wr_data,
    input logic [REG_W-1:0]  sys_rd_data,
    input logic [REG_W-1:0]  en_set,
    input logic [REG_W-1:0]  ovf_flags,
    input logic              dbg_sel,
    input logic              dbg_wr,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [REG_W-1:0]  dbg_rdata,
    input logic              dbg_err,
    input logic              core_pwr,
    input logic              dbl_lock,
    input logic              os_lock,
    input logic              ext_pmu_ok,
    input logic              sw_lock,
    input logic              irq
);
    localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_EVT);
    logic at_reg, reach;
    assign at_reg = dbg_sel && (dbg_addr == ADDR_W'(REG_OFFSET));
    assign reach  = core_pwr && !dbl_lock && !os_lock && ext_pmu_ok;

    p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rd_data & ~IMPL) == '0);

    p_clear_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sys_wr_en |=> ((sys_rd_data & $past(sys_wr_data)) == '0));

    p_err_grade_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (at_reg && !reach) |-> (dbg_err && dbg_rdata == '0));

    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_err && !sys_wr_en && en_set == '0) |=> $stable(sys_rd_data));

    p_ro_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_reg && dbg_wr && reach && sw_lock && !sys_wr_en && en_set == '0)
        |=> $stable(sys_rd_data));

    p_wr_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr || !dbg_sel) |-> (dbg_rdata == '0));

    p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel && !at_reg) |-> (!dbg_err && dbg_rdata == '0));

    p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(ovf_flags) & sys_rd_data)));
endmodule

bind ovf_irq_mask ovf_irq_mask_chk #(
    .NUM_EVT    (NUM_EVT),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_wr_en   (sys_wr_en),
    .sys_wr_data (sys_wr_data),
    .sys_rd_data (sys_rd_data),
    .en_set      (en_set),
    .ovf_flags   (ovf_flags),
    .dbg_sel     (dbg_sel),
    .dbg_wr      (dbg_wr),
    .dbg_addr    (dbg_addr),
    .dbg_rdata   (dbg_rdata),
    .dbg_err     (dbg_err),
    .core_pwr    (core_pwr),
    .dbl_lock    (dbl_lock),
    .os_lock     (os_lock),
    .ext_pmu_ok  (ext_pmu_ok),
    .sw_lock     (sw_lock),
    .irq         (irq)
);

// File: tb/ovf_irq_mask_tb_top.sv
// Bench for ovf_irq_mask: a vector table for the external port, then
// directed tests. NUM_EVT=6, so implemented bits are 0x8000_003F.
module ovf_irq_mask_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IMPL = 32'h8000_003F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sys_wr_en;
    logic [31:0] sys_wr_data, sys_rd_data, en_set, ovf_flags;
    logic        dbg_sel, dbg_wr, dbg_err;
    logic [11:0] dbg_addr;
    logic [31:0] dbg_wdata, dbg_rdata;
    logic        core_pwr, dbl_lock, os_lock, ext_pmu_ok, sw_lock, irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovf_irq_mask dut_i (
        .clk(clk), .rst_n(rst_n), .sys_wr_en(sys_wr_en),
        .sys_wr_data(sys_wr_data), .sys_rd_data(sys_rd_data),
        .en_set(en_set), .ovf_flags(ovf_flags), .dbg_sel(dbg_sel),
        .dbg_wr(dbg_wr), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .dbg_err(dbg_err), .core_pwr(core_pwr),
        .dbl_lock(dbl_lock), .os_lock(os_lock), .ext_pmu_ok(ext_pmu_ok),
        .sw_lock(sw_lock), .irq(irq)
    );

    // st = {core_pwr, dbl_lock, os_lock, ext_pmu_ok, sw_lock}
    typedef struct packed {
        logic [4:0]  st;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        exp_err;
        logic [31:0] exp_rd;
        logic [31:0] exp_mask;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'b10010, 1'b0, 12'hC60, 32'h0,         1'b0, 32'h8000_003F, 32'h8000_003F}, // R8 read
        '{5'b10010, 1'b1, 12'hC60, 32'h0000_0005, 1'b0, 32'h0,         32'h8000_003A}, // R8 clear
        '{5'b10010, 1'b1, 12'hC60, 32'hFFFF_FFC0, 1'b0, 32'h0,         32'h0000_003F}, // R8 cycle bit
        '{5'b10011, 1'b1, 12'hC60, 32'hFFFF_FFFF, 1'b0, 32'h0,         32'h8000_003F}, // R7 drop
        '{5'b10011, 1'b0, 12'hC60, 32'h0,         1'b0, 32'h8000_003F, 32'h8000_003F}, // R7 read
        '{5'b00010, 1'b0, 12'hC60, 32'h0,         1'b1, 32'h0,         32'h8000_003F}, // R6 no power
        '{5'b11010, 1'b1, 12'hC60, 32'hFFFF_FFFF, 1'b1, 32'h0,         32'h8000_003F}, // R6 double lock
        '{5'b10110, 1'b1, 12'hC60, 32'hFFFF_FFFF, 1'b1, 32'h0,         32'h8000_003F}, // R6 os lock
        '{5'b10000, 1'b1, 12'hC60, 32'hFFFF_FFFF, 1'b1, 32'h0,         32'h8000_003F}, // R6 denied
        '{5'b10010, 1'b1, 12'hC64, 32'hFFFF_FFFF, 1'b0, 32'h0,         32'h8000_003F}  // R10 miss
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_dbg();
        dbg_sel = 0; dbg_wr = 0; dbg_addr = 12'h0; dbg_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; sys_wr_en = 0; sys_wr_data = '0; en_set = '0; ovf_flags = '0;
        idle_dbg();
        {core_pwr, dbl_lock, os_lock, ext_pmu_ok, sw_lock} = 5'b10010;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 mask after reset", sys_rd_data, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        // Table walk: preset all bits, then one external access per vector.
        for (int v = 0; v < NV; v++) begin
            string tag;
            en_set = 32'hFFFF_FFFF;
            @(negedge clk);
            en_set = '0;
            {core_pwr, dbl_lock, os_lock, ext_pmu_ok, sw_lock} = VECS[v].st;
            dbg_sel = 1; dbg_wr = VECS[v].wr; dbg_addr = VECS[v].addr;
            dbg_wdata = VECS[v].wdata;
            #1;
            if (VECS[v].exp_err)            tag = "R6";
            else if (VECS[v].addr != 12'hC60) tag = "R10";
            else if (VECS[v].st[0])         tag = "R7";
            else                            tag = "R8";
            chk($sformatf("%s vec%0d err", tag, v), {31'h0, dbg_err}, {31'h0, VECS[v].exp_err});
            chk($sformatf("%s R9 vec%0d rdata", tag, v), dbg_rdata, VECS[v].exp_rd);
            @(negedge clk);
            idle_dbg();
            {core_pwr, dbl_lock, os_lock, ext_pmu_ok, sw_lock} = 5'b10010;
            chk($sformatf("%s vec%0d mask", tag, v), sys_rd_data, VECS[v].exp_mask);
        end

        // R4: setting every bit leaves unimplemented bits at zero.
        chk("R4 tied bits", sys_rd_data & ~IMPL, 32'h0);
        chk("R3 read shows mask", sys_rd_data, IMPL);

        // R2: writing zero changes nothing; single bit clears only itself.
        sys_wr_en = 1; sys_wr_data = 32'h0;
        @(negedge clk);
        chk("R2 zero write", sys_rd_data, IMPL);
        sys_wr_data = 32'h0000_0010;
        @(negedge clk);
        sys_wr_en = 0;
        chk("R2 single clear", sys_rd_data, 32'h8000_002F);

        // R5: set and clear of bit 4 together, clear wins; set bit 4 alone.
        en_set = 32'h0000_0010; sys_wr_en = 1; sys_wr_data = 32'h0000_0010;
        @(negedge clk);
        sys_wr_en = 0;
        chk("R5 clear beats set", sys_rd_data, 32'h8000_002F);
        @(negedge clk);
        en_set = '0;
        chk("R5 set", sys_rd_data, IMPL);

        // R12: system clears bit 0 while external clears bit 1.
        sys_wr_en = 1; sys_wr_data = 32'h1;
        dbg_sel = 1; dbg_wr = 1; dbg_addr = 12'hC60; dbg_wdata = 32'h2;
        @(negedge clk);
        sys_wr_en = 0; idle_dbg();
        chk("R12 combined clear", sys_rd_data, 32'h8000_003C);

        // R11: overflow on enabled bit 3 raises irq after one edge.
        ovf_flags = 32'h0000_0008;
        #1;
        chk("R11 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R11 irq raised", {31'h0, irq}, 32'h1);
        sys_wr_en = 1; sys_wr_data = 32'h8;
        @(negedge clk);
        sys_wr_en = 0;
        chk("R11 irq drops with clear", {31'h0, irq}, 32'h0);
        ovf_flags = 32'h0000_0002;
        @(negedge clk);
        chk("R11 disabled flag ignored", {31'h0, irq}, 32'h0);
        ovf_flags = 32'h8000_0000;
        @(negedge clk);
        chk("R11 cycle counter irq", {31'h0, irq}, 32'h1);
        ovf_flags = '0;

        // R1: reset mid-run clears the mask.
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 mid-run reset", sys_rd_data, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule